// File: doc/BRIEF.md
# Inter-Processor Circular Queue Manager

This block manages the bookkeeping for circular queues of message pointers that two processors use to talk to each other. There are `2*NQ` queues. Queues `0..NQ-1` are the send queues of processor 0 and the receive queues of processor 1. Queues `NQ..2*NQ-1` are the send queues of processor 1 and the receive queues of processor 0. Each processor reaches every queue through its own register port with the same layout. The sending side writes the put index, the last valid index, and a base address of `ADDR_W` bits. The receiving side writes the get index. Both sides can read everything.

An index runs from 0 up to the last index and then starts again at 0. The block computes `base + 4*index` for both indices. It reports, per queue, whether the queue is empty or full, and it raises a not-empty line toward the receiver. Either side can ask its peer to clear both indices. The clear only happens when the peer confirms while that request is pending.

The register address is `{dir, slot, sel}`. `dir` is 0 for the port's own send queue and 1 for its receive queue. `slot` selects the queue within that side, and `sel` is 3 bits wide. Reads are combinational. A write takes effect at the next clock edge.

Top module: `ipcq_mgr`

## Requirements
- R1: A send queue at slot j of one port is the same queue as the receive queue at slot j of the other port. A put index written through one port reads back through the other.
- R2: In the index register (sel=0), bits [15:0] hold the put index and bits [31:16] hold the get index. A write by the sender changes only the put index. A write by the receiver changes only the get index.
- R3: An index write whose value is above the queue's last index stores 0. A value at or below the last index is stored unchanged.
- R4: The control register is sel=1, with the last index in bits [15:0]. The base address is split into its low 32 bits (sel=2) and its upper bits (sel=3). Only the sender can change the last index and the base address. Writes to these from the receiver leave them unchanged.
- R5: The get-address reads as sel=4 (low 32 bits) and sel=5 (upper bits). The put-address reads as sel=6 (low) and sel=7 (upper). Each equals `base + 4*index` modulo 2^ADDR_W.
- R6: A queue is empty when put equals get. It is full when the successor of put equals get, where the successor of the last index is 0. With a last index of 0, both flags are set.
- R7: For each of its receive slots, a processor's not-empty line is high exactly when that queue is not empty.
- R8: Writing control bit 25 raises the writer's reset request. The other side sees it as bit 16 of its control register, and the writer sees it as bit 17. Writing control bit 24 while the peer's request is pending does three things: it clears put and get to 0, it clears that request, and it keeps the last index.
- R9: Writing control bit 24 while no peer request is pending leaves both indices and both request flags unchanged.
- R10: When both ports write the same queue in one cycle, the result is as if processor 0's write were applied first and processor 1's write second.
- R11: After reset, all indices, base addresses and requests are 0 and every last index equals RST_LAST. All queues then report empty and not full, and all not-empty lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| p0_we | input | 1 | Processor 0 write strobe |
| p0_addr | input | AW (6) | Processor 0 register address {dir, slot, sel} |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data for p0_addr |
| p1_we | input | 1 | Processor 1 write strobe |
| p1_addr | input | AW (6) | Processor 1 register address {dir, slot, sel} |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data for p1_addr |
| q_empty | output | 2*NQ | Empty flag per queue, indexed by queue number |
| q_full | output | 2*NQ | Full flag per queue, indexed by queue number |
| p0_rx_nempty | output | NQ | Not-empty lines for processor 0's receive slots |
| p1_rx_nempty | output | NQ | Not-empty lines for processor 1's receive slots |

## Verification
The bench builds the block with IDX_W=4, NQ=4 and ADDR_W=36. The narrow index lets it cover every last index from 0 to 15 and, for each one, every legal put/get pair. That is every empty and full case, including the single-slot queue and the wrap from the last index to 0. The same narrow index lets the bench try every write value against the clamp. The 36-bit address, together with a base just below the top of the range, forces the address sum to wrap. Same-cycle writes from both ports are driven in both role arrangements, so the fixed ordering is visible both when it blocks a reset and when it enables one.

// File: rtl/ipcq_pkg.sv
package ipcq_pkg;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 16;
  localparam int SEL_W     = 3;
  localparam int B_PEER    = 16;
  localparam int B_OWN     = 17;
  localparam int B_CONFIRM = 24;
  localparam int B_RAISE   = 25;

  typedef enum logic [SEL_W-1:0] {
    RS_PTR  = 3'd0,
    RS_CTRL = 3'd1,
    RS_BLO  = 3'd2,
    RS_BHI  = 3'd3,
    RS_GALO = 3'd4,
    RS_GAHI = 3'd5,
    RS_PALO = 3'd6,
    RS_PAHI = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic             wr_ptr;
    logic             wr_ctrl;
    logic             wr_blo;
    logic             wr_bhi;
    logic [REG_W-1:0] data;
  } qop_t;
endpackage

// File: rtl/ipcq_rst_sync.sv
module ipcq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta       <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta       <= 1'b1;
      rst_sync_n <= meta;
    end
  end
endmodule

// File: rtl/ipcq_queue.sv
module ipcq_queue
  import ipcq_pkg::*;
#(
  parameter int              IDX_W    = 16,
  parameter int              ADDR_W   = 36,
  parameter logic [IDX_W-1:0] RST_LAST = '1,
  parameter int              SND_PORT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qop_t              op_p0,
  input  qop_t              op_p1,
  output logic [IDX_W-1:0]  put_o,
  output logic [IDX_W-1:0]  get_o,
  output logic [IDX_W-1:0]  last_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] put_addr_o,
  output logic [ADDR_W-1:0] get_addr_o,
  output logic              sreq_o,
  output logic              rreq_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int HI_W = ADDR_W - REG_W;
  localparam logic SND0 = (SND_PORT == 0);

  typedef struct packed {
    logic [IDX_W-1:0]  put;
    logic [IDX_W-1:0]  get;
    logic [IDX_W-1:0]  last;
    logic [ADDR_W-1:0] base;
    logic              sreq;
    logic              rreq;
  } qst_t;

  localparam qst_t RST_ST = '{put: '0, get: '0, last: RST_LAST, base: '0,
                              sreq: 1'b0, rreq: 1'b0};

  // One port's write, seen from its role on this queue.
  function automatic qst_t apply(qst_t s, qop_t op, logic snd);
    qst_t             n;
    logic [IDX_W-1:0] v;
    logic             peer;
    n    = s;
    peer = 1'b0;
    v    = snd ? op.data[IDX_W-1:0] : op.data[FLD_W +: IDX_W];
    if (op.wr_ptr) begin
      if (v > n.last) v = '0;
      if (snd) n.put = v;
      else     n.get = v;
    end
    if (op.wr_ctrl) begin
      if (snd) n.last = op.data[IDX_W-1:0];
      peer = snd ? n.rreq : n.sreq;
      if (op.data[B_CONFIRM] && peer) begin
        n.put = '0;
        n.get = '0;
        if (snd) n.rreq = 1'b0;
        else     n.sreq = 1'b0;
      end
      if (op.data[B_RAISE]) begin
        if (snd) n.sreq = 1'b1;
        else     n.rreq = 1'b1;
      end
    end
    if (op.wr_blo && snd) n.base[REG_W-1:0]      = op.data;
    if (op.wr_bhi && snd) n.base[ADDR_W-1:REG_W] = op.data[HI_W-1:0];
    return n;
  endfunction

  qst_t cur, mid, nxt;
  logic en;
  qop_t snd_op;

  assign snd_op = SND0 ? op_p0 : op_p1;
  assign en = op_p0.wr_ptr | op_p0.wr_ctrl | op_p0.wr_blo | op_p0.wr_bhi |
              op_p1.wr_ptr | op_p1.wr_ctrl | op_p1.wr_blo | op_p1.wr_bhi;

  // Processor 0 first, processor 1 sees its result.
  always_comb begin
    mid = apply(cur, op_p0, SND0);
    nxt = apply(mid, op_p1, !SND0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur <= RST_ST;
    else if (en) cur <= nxt;
  end

  logic [IDX_W-1:0] put_succ;
  assign put_succ   = (cur.put == cur.last) ? '0 : cur.put + 1'b1;
  assign empty_o    = (cur.put == cur.get);
  assign full_o     = (put_succ == cur.get);
  assign put_o      = cur.put;
  assign get_o      = cur.get;
  assign last_o     = cur.last;
  assign base_o     = cur.base;
  assign sreq_o     = cur.sreq;
  assign rreq_o     = cur.rreq;
  assign put_addr_o = cur.base + ADDR_W'({cur.put, 2'b00});
  assign get_addr_o = cur.base + ADDR_W'({cur.get, 2'b00});

  a_r6_both_only_single: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && full_o) |-> (cur.last == '0));

  a_r3_put_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    snd_op.wr_ptr |=> (cur.put <= cur.last));

  a_r4_base_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(snd_op.wr_blo || snd_op.wr_bhi) |=> $stable(cur.base));

  a_r8_recv_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.rreq) |-> (cur.put == '0));

  a_r8_send_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.sreq) |-> (cur.get == '0));
endmodule

// File: rtl/ipcq_port.sv
module ipcq_port
  import ipcq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 36,
  parameter int PORT   = 0,
  parameter int SLOT_W = 2,
  parameter int AW     = 6
) (
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [IDX_W-1:0]  q_put    [2*NQ],
  input  logic [IDX_W-1:0]  q_get    [2*NQ],
  input  logic [IDX_W-1:0]  q_last   [2*NQ],
  input  logic [ADDR_W-1:0] q_base   [2*NQ],
  input  logic [ADDR_W-1:0] q_paddr  [2*NQ],
  input  logic [ADDR_W-1:0] q_gaddr  [2*NQ],
  input  logic              q_sreq   [2*NQ],
  input  logic              q_rreq   [2*NQ],
  output qop_t              ops      [2*NQ],
  output logic [REG_W-1:0]  rdata
);
  localparam int NT    = 2 * NQ;
  localparam int QW    = $clog2(NT);
  localparam int HI_W  = ADDR_W - REG_W;
  localparam int OTHER = 1 - PORT;

  logic              dir;
  logic [SLOT_W-1:0] slot;
  reg_sel_e          sel;
  logic [QW-1:0]     qi;

  assign dir  = addr[AW-1];
  assign slot = addr[SEL_W +: SLOT_W];
  assign sel  = reg_sel_e'(addr[SEL_W-1:0]);
  assign qi   = dir ? QW'(OTHER * NQ) + QW'(slot) : QW'(PORT * NQ) + QW'(slot);

  for (genvar q = 0; q < NT; q++) begin : g_dec
    logic hit;
    assign hit            = we && (qi == QW'(q));
    assign ops[q].wr_ptr  = hit && (sel == RS_PTR);
    assign ops[q].wr_ctrl = hit && (sel == RS_CTRL);
    assign ops[q].wr_blo  = hit && (sel == RS_BLO);
    assign ops[q].wr_bhi  = hit && (sel == RS_BHI);
    assign ops[q].data    = wdata;
  end

  always_comb begin
    rdata = '0;
    case (sel)
      RS_PTR: begin
        rdata[FLD_W-1:0]     = FLD_W'(q_put[qi]);
        rdata[REG_W-1:FLD_W] = FLD_W'(q_get[qi]);
      end
      RS_CTRL: begin
        rdata[FLD_W-1:0] = FLD_W'(q_last[qi]);
        rdata[B_PEER]    = dir ? q_sreq[qi] : q_rreq[qi];
        rdata[B_OWN]     = dir ? q_rreq[qi] : q_sreq[qi];
      end
      RS_BLO:  rdata = q_base[qi][REG_W-1:0];
      RS_BHI:  rdata = REG_W'(q_base[qi][ADDR_W-1:REG_W]);
      RS_GALO: rdata = q_gaddr[qi][REG_W-1:0];
      RS_GAHI: rdata = REG_W'(q_gaddr[qi][ADDR_W-1:REG_W]);
      RS_PALO: rdata = q_paddr[qi][REG_W-1:0];
      RS_PAHI: rdata = REG_W'(q_paddr[qi][ADDR_W-1:REG_W]);
      default: rdata = '0;
    endcase
  end

  logic [HI_W-1:0] unused_hi_w;
  assign unused_hi_w = '0;
endmodule

// File: rtl/ipcq_mgr.sv
module ipcq_mgr
  import ipcq_pkg::*;
#(
  parameter int               NQ       = 4,
  parameter int               IDX_W    = 16,
  parameter int               ADDR_W   = 36,
  parameter logic [IDX_W-1:0] RST_LAST = '1,
  localparam int              SLOT_W   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int              AW       = 1 + SLOT_W + SEL_W,
  localparam int              NT       = 2 * NQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p0_we,
  input  logic [AW-1:0]    p0_addr,
  input  logic [REG_W-1:0] p0_wdata,
  output logic [REG_W-1:0] p0_rdata,
  input  logic             p1_we,
  input  logic [AW-1:0]    p1_addr,
  input  logic [REG_W-1:0] p1_wdata,
  output logic [REG_W-1:0] p1_rdata,
  output logic [NT-1:0]    q_empty,
  output logic [NT-1:0]    q_full,
  output logic [NQ-1:0]    p0_rx_nempty,
  output logic [NQ-1:0]    p1_rx_nempty
);
  logic              rst_i_n;
  qop_t              ops0    [NT];
  qop_t              ops1    [NT];
  logic [IDX_W-1:0]  q_put   [NT];
  logic [IDX_W-1:0]  q_get   [NT];
  logic [IDX_W-1:0]  q_last  [NT];
  logic [ADDR_W-1:0] q_base  [NT];
  logic [ADDR_W-1:0] q_paddr [NT];
  logic [ADDR_W-1:0] q_gaddr [NT];
  logic              q_sreq  [NT];
  logic              q_rreq  [NT];

  ipcq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  ipcq_port #(.NQ(NQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PORT(0),
              .SLOT_W(SLOT_W), .AW(AW)) u_port0 (
    .we(p0_we), .addr(p0_addr), .wdata(p0_wdata),
    .q_put(q_put), .q_get(q_get), .q_last(q_last), .q_base(q_base),
    .q_paddr(q_paddr), .q_gaddr(q_gaddr), .q_sreq(q_sreq), .q_rreq(q_rreq),
    .ops(ops0), .rdata(p0_rdata));

  ipcq_port #(.NQ(NQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .PORT(1),
              .SLOT_W(SLOT_W), .AW(AW)) u_port1 (
    .we(p1_we), .addr(p1_addr), .wdata(p1_wdata),
    .q_put(q_put), .q_get(q_get), .q_last(q_last), .q_base(q_base),
    .q_paddr(q_paddr), .q_gaddr(q_gaddr), .q_sreq(q_sreq), .q_rreq(q_rreq),
    .ops(ops1), .rdata(p1_rdata));

  for (genvar q = 0; q < NT; q++) begin : g_q
    ipcq_queue #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .RST_LAST(RST_LAST),
                 .SND_PORT(q / NQ)) u_q (
      .clk(clk), .rst_n(rst_i_n), .op_p0(ops0[q]), .op_p1(ops1[q]),
      .put_o(q_put[q]), .get_o(q_get[q]), .last_o(q_last[q]),
      .base_o(q_base[q]), .put_addr_o(q_paddr[q]), .get_addr_o(q_gaddr[q]),
      .sreq_o(q_sreq[q]), .rreq_o(q_rreq[q]),
      .empty_o(q_empty[q]), .full_o(q_full[q]));
  end

  assign p0_rx_nempty = ~q_empty[NQ +: NQ];
  assign p1_rx_nempty = ~q_empty[0 +: NQ];
endmodule

// File: tb/ipcq_mgr_bench.sv
`timescale 1ns/1ps
module ipcq_mgr_bench;
  localparam int NQ = 4, IDX_W = 4, ADDR_W = 36;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        p0_we, p1_we;
  logic [5:0]  p0_addr, p1_addr;
  logic [31:0] p0_wdata, p1_wdata, p0_rdata, p1_rdata;
  logic [7:0]  q_empty, q_full;
  logic [3:0]  p0_rx_nempty, p1_rx_nempty;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  ipcq_mgr #(.NQ(NQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ipcq_mgr (
    .clk(clk), .rst_n(rst_n),
    .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .q_empty(q_empty), .q_full(q_full),
    .p0_rx_nempty(p0_rx_nempty), .p1_rx_nempty(p1_rx_nempty));

  function automatic logic [5:0] ra(input int dir, input int slot, input int sel);
    return {dir[0], slot[1:0], sel[2:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin p0_we = 1'b1; p0_addr = a; p0_wdata = d; end
    else        begin p1_we = 1'b1; p1_addr = a; p1_wdata = d; end
    @(negedge clk);
    p0_we = 1'b0; p1_we = 1'b0;
  endtask

  task automatic wr2(input logic [5:0] a0, input logic [31:0] d0,
                     input logic [5:0] a1, input logic [31:0] d1);
    @(negedge clk);
    p0_we = 1'b1; p0_addr = a0; p0_wdata = d0;
    p1_we = 1'b1; p1_addr = a1; p1_wdata = d1;
    @(negedge clk);
    p0_we = 1'b0; p1_we = 1'b0;
  endtask

  task automatic rd(input int p, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    if (p == 0) p0_addr = a; else p1_addr = a;
    #1;
    d = (p == 0) ? p0_rdata : p1_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [35:0] ea;
    rst_n = 1'b0; p0_we = 1'b0; p1_we = 1'b0;
    p0_addr = '0; p1_addr = '0; p0_wdata = '0; p1_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    #1;
    chk("R11 empty", q_empty, 8'hFF);
    chk("R11 full", q_full, 8'h00);
    chk("R11 nempty", {p0_rx_nempty, p1_rx_nempty}, 8'h00);
    rd(0, ra(0, 0, 1), d); chk("R11 ctrl", d, 32'h0000_000F);
    rd(1, ra(1, 2, 2), d); chk("R11 base", d, 32'h0);
    rd(1, ra(0, 3, 0), d); chk("R11 ptr", d, 32'h0);

    // R1 R2 R7 cross mapping and field ownership
    for (int p = 0; p < 2; p++) begin
      for (int j = 0; j < NQ; j++) begin
        wr(p, ra(0, j, 0), j + 1);
        rd(1 - p, ra(1, j, 0), d); chk("R1 put via peer", d, 32'(j + 1));
        chk("R6 not empty", q_empty[p*NQ+j], 1'b0);
        chk("R7 irq high", (p == 0) ? p1_rx_nempty[j] : p0_rx_nempty[j], 1'b1);
        wr(1 - p, ra(1, j, 0), ((j + 1) << 16) | 32'h3);
        rd(p, ra(0, j, 0), d); chk("R2 ptr fields", d, ((j + 1) << 16) | (j + 1));
        chk("R7 irq low", (p == 0) ? p1_rx_nempty[j] : p0_rx_nempty[j], 1'b0);
      end
    end

    // R6 R7 sweep of every last index and every put/get pair on queue 0
    for (int s = 0; s < 16; s++) begin
      wr(0, ra(0, 0, 1), s);
      for (int pu = 0; pu <= s; pu++) begin
        for (int g = 0; g <= s; g++) begin
          logic e, f;
          wr2(ra(0, 0, 0), pu, ra(1, 0, 0), g << 16);
          #1;
          e = (pu == g);
          f = (((pu == s) ? 0 : pu + 1) == g);
          chk("R6 R7 flags", {q_empty[0], q_full[0], p1_rx_nempty[0]}, {e, f, !e});
        end
      end
    end

    // R3 clamp on queue 4 (processor 1 sends)
    wr(1, ra(0, 0, 1), 5);
    for (int v = 0; v < 16; v++) begin
      wr(1, ra(0, 0, 0), v);
      rd(1, ra(0, 0, 0), d); chk("R3 put clamp", d[15:0], (v > 5) ? 0 : v);
    end
    wr(0, ra(1, 0, 0), 9 << 16);
    rd(0, ra(1, 0, 0), d); chk("R3 get clamp", d[31:16], 16'h0);
    wr(0, ra(1, 0, 0), 4 << 16);
    rd(0, ra(1, 0, 0), d); chk("R3 get keep", d[31:16], 16'h4);

    // R4 owner-only fields
    wr(1, ra(0, 0, 2), 32'hFFFF_FFF0);
    wr(1, ra(0, 0, 3), 32'hF);
    wr(0, ra(1, 0, 1), 32'h2);
    wr(0, ra(1, 0, 2), 32'h1234);
    wr(0, ra(1, 0, 3), 32'h3);
    rd(0, ra(1, 0, 1), d); chk("R4 last kept", d[15:0], 16'h5);
    rd(0, ra(1, 0, 2), d); chk("R4 base lo kept", d, 32'hFFFF_FFF0);
    rd(0, ra(1, 0, 3), d); chk("R4 base hi kept", d, 32'hF);

    // R5 address sums with 36-bit wrap
    wr(1, ra(0, 0, 0), 3);
    wr(0, ra(1, 0, 0), 5 << 16);
    ea = 36'hF_FFFF_FFF0 + 36'(3 * 4);
    rd(1, ra(0, 0, 6), d); chk("R5 put addr lo", d, ea[31:0]);
    rd(1, ra(0, 0, 7), d); chk("R5 put addr hi", d, 32'(ea[35:32]));
    ea = 36'hF_FFFF_FFF0 + 36'(5 * 4);
    rd(0, ra(1, 0, 4), d); chk("R5 get addr lo", d, ea[31:0]);
    rd(0, ra(1, 0, 5), d); chk("R5 get addr hi", d, 32'(ea[35:32]));

    // R8 receiver requests, sender confirms
    wr(0, ra(1, 0, 1), 32'h1 << 25);
    rd(1, ra(0, 0, 1), d); chk("R8 peer sees req", d[16], 1'b1);
    rd(0, ra(1, 0, 1), d); chk("R8 own req", d[17], 1'b1);
    wr(1, ra(0, 0, 1), (32'h1 << 24) | 5);
    rd(1, ra(0, 0, 0), d); chk("R8 cleared ptrs", d, 32'h0);
    rd(1, ra(0, 0, 1), d); chk("R8 req gone", d, 32'h5);

    // R9 confirm with nothing pending
    wr(1, ra(0, 0, 0), 2);
    wr(1, ra(0, 0, 1), (32'h1 << 24) | 5);
    rd(1, ra(0, 0, 0), d); chk("R9 sender confirm ignored", d, 32'h2);
    wr(0, ra(1, 0, 1), 32'h1 << 24);
    rd(0, ra(1, 0, 0), d); chk("R9 receiver confirm ignored", d, 32'h2);

    // R8 sender requests, receiver confirms
    wr(1, ra(0, 0, 1), (32'h1 << 25) | 5);
    rd(0, ra(1, 0, 1), d); chk("R8 recv sees req", d[16], 1'b1);
    wr(0, ra(1, 0, 1), 32'h1 << 24);
    rd(0, ra(1, 0, 0), d); chk("R8 recv reset ptrs", d, 32'h0);
    rd(0, ra(1, 0, 1), d); chk("R8 recv req gone", d[17:16], 2'b00);

    // R10 same-cycle ordering, queue 0: confirm (p0) before raise (p1)
    wr(0, ra(0, 0, 0), 4);
    wr2(ra(0, 0, 1), (32'h1 << 24) | 15, ra(1, 0, 1), 32'h1 << 25);
    rd(0, ra(0, 0, 0), d); chk("R10 early confirm ignored", d[15:0], 16'h4);
    rd(0, ra(0, 0, 1), d); chk("R10 req left set", d[16], 1'b1);
    wr2(ra(0, 0, 1), (32'h1 << 24) | 15, ra(1, 0, 0), 32'h2 << 16);
    rd(0, ra(0, 0, 0), d); chk("R10 reset then get write", d, 32'h0002_0000);
    rd(0, ra(0, 0, 1), d); chk("R10 req cleared", d[16], 1'b0);

    // R10 queue 4: raise (p0) before confirm (p1)
    wr(1, ra(0, 0, 0), 3);
    wr2(ra(1, 0, 1), 32'h1 << 25, ra(0, 0, 1), (32'h1 << 24) | 5);
    rd(1, ra(0, 0, 0), d); chk("R10 raise then confirm", d, 32'h0);
    rd(1, ra(0, 0, 1), d); chk("R10 req consumed", d[16], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule